// File: doc/BRIEF.md
# Vector Prefix Byte-Stream Decoder

This block sits at the front of an instruction decoder that runs in 64-bit mode. It takes instruction bytes one at a time over a valid/ready handshake and decides, from the first byte of each instruction, whether a vector-extension prefix follows. A lead byte of 0xC5 opens the short (two-byte) prefix. A lead byte of 0xC4 opens the long (three-byte) prefix. Any other first byte is passed through unchanged and marked as not prefixed.

Once the last prefix byte is taken, the block unpacks the fields into a record. The record holds the prefix length, the register-extension bits, the opcode map, the widening bit, the extra source register index, the vector length and the implied legacy prefix. It appears for one cycle, on the cycle after that byte is accepted.

Four qualifier inputs describe the instruction that follows the prefix. They are sampled together with the final byte and refine the record:
- whether the operation is scalar,
- whether it has a single source,
- whether it belongs to the shift class that keeps the extra register,
- whether the widening bit is to be disregarded.

A flush input drops any partly collected prefix between instructions.

Top module: `vex_prefix_decoder`

## Requirements
- R1: `in_ready` is high whenever the internal reset is released and `flush` is low. It is low while `flush` is high. A byte is taken only on a cycle where `in_valid` and `in_ready` are both high.
- R2: A first byte of 0xC5 starts the short form, and the record uses the next byte taken. Its layout is bit 7 = inverted R, bits 6:3 = inverted register field, bit 2 = L, bits 1:0 = pp. The record shows `rec_prefixed`=1, `rec_len`=2, `rec_map`=1 (0F map), and `rec_x`=`rec_b`=0.
- R3: A first byte of 0xC4 starts the long form, with two more bytes. In byte 2, bit 7 is inverted R, bit 6 is inverted X, bit 5 is inverted B, and bits 4:0 are the map select. In byte 3, bit 7 is W, bits 6:3 are the inverted register field, bit 2 is L, and bits 1:0 are pp. The record shows `rec_len`=3, and `rec_r`, `rec_x`, `rec_b` are the complements of the stored bits.
- R4: In the long form, map select 1, 2 and 3 give `rec_map` codes 1, 2 and 3 (0F, 0F38, 0F3A) with `rec_illegal`=0. Any other value gives `rec_illegal`=1 and `rec_map`=0.
- R5: `rec_vreg` is the bitwise complement of the stored 4-bit register field, so 4'b1111 gives 0 and 4'b0000 gives 15.
- R6: `rec_w` is always 0 for the short form. For the long form, `rec_w` is the W bit, except that it is 0 when `w_ignored` is high. `rec_w_ignored` echoes `w_ignored`.
- R7: `rec_vlen` is 1 (256-bit) when L=1. It is 0 (128-bit) when L=0 and `scalar_op` is low. It is 2 (scalar) when L=0 and `scalar_op` is high.
- R8: `rec_vreg_used` is 0 when `single_src` is high and `shift_class` is low. It is 1 in every other case.
- R9: `rec_pp` carries pp unchanged. The codes are 0 for no implied prefix, 1 for 66, 2 for F3 and 3 for F2.
- R10: Any first byte other than 0xC4 or 0xC5 produces a record on the next cycle. That record has `rec_prefixed`=0, `rec_len`=0, the byte on `rec_byte`, and every other field 0, whatever the qualifier inputs are.
- R11: `flush` returns the collector to idle. A partly collected prefix yields no record, and the next byte taken is handled as a first byte.
- R12: While the internal reset is active, and for two cycles after `rst_n` rises, `in_ready` and `rec_valid` are low.
- R13: `rec_valid` is high for exactly the one cycle after the final byte of an instruction is taken. It stays low while a prefix is incomplete, and cycles without a byte taken do not advance the collector.
- R14: The qualifier inputs are sampled on the cycle the final byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard any partial prefix |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Instruction byte |
| scalar_op | input | 1 | Instruction is a scalar operation |
| single_src | input | 1 | Instruction has a single source |
| shift_class | input | 1 | Instruction is a shift that keeps the extra register |
| w_ignored | input | 1 | Instruction disregards the widening bit |
| rec_valid | output | 1 | Record valid this cycle |
| rec_prefixed | output | 1 | Record came from a prefix |
| rec_len | output | 2 | Prefix length in bytes (0, 2, 3) |
| rec_r | output | 1 | Register extension R |
| rec_x | output | 1 | Index extension X |
| rec_b | output | 1 | Base extension B |
| rec_map | output | 2 | Opcode map code |
| rec_illegal | output | 1 | Map select not legal |
| rec_w | output | 1 | Effective widening bit |
| rec_w_ignored | output | 1 | Widening bit to be disregarded |
| rec_vreg | output | 4 | Extra source register index |
| rec_vreg_used | output | 1 | Extra register field is meaningful |
| rec_vlen | output | 2 | Vector length code |
| rec_pp | output | 2 | Implied legacy prefix code |
| rec_byte | output | 8 | Raw byte of a non-prefixed instruction |

## Verification
The bench builds the block with its default parameters. These are lead bytes 0xC5 and 0xC4, and a two-stage reset synchroniser. With them, the bench can check the exact cycle on which ready appears after reset. It can also check the exact record cycle after each prefix form. The tests include a lead byte value showing up as a payload byte, and map selects at both sides of the legal range. They also cover a flush that cuts a long prefix after its second byte, so that the following byte must come out as a plain instruction.

// File: rtl/vexdec_pkg.sv
package vexdec_pkg;

  localparam int BYTE_W = 8;
  localparam int VREG_W = 4;
  localparam int SEL_W  = 5;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SHORT_P1 = 2'd1,
    ST_LONG_P1  = 2'd2,
    ST_LONG_P2  = 2'd3
  } col_state_e;

  // value equals the prefix length in bytes
  typedef enum logic [1:0] {
    FORM_NONE  = 2'd0,
    FORM_SHORT = 2'd2,
    FORM_LONG  = 2'd3
  } form_e;

  typedef enum logic [1:0] {
    MAP_NONE = 2'd0,
    MAP_0F   = 2'd1,
    MAP_0F38 = 2'd2,
    MAP_0F3A = 2'd3
  } map_e;

  typedef enum logic [1:0] {
    VL_128    = 2'd0,
    VL_256    = 2'd1,
    VL_SCALAR = 2'd2
  } vlen_e;

  typedef struct packed {
    logic              prefixed;
    form_e             len;
    logic              r;
    logic              x;
    logic              b;
    map_e              map;
    logic              illegal;
    logic              w;
    logic              w_ign;
    logic [VREG_W-1:0] vreg;
    logic              vreg_used;
    vlen_e             vlen;
    logic [1:0]        pp;
    logic [BYTE_W-1:0] raw;
  } rec_t;

endpackage

// File: rtl/vexdec_collector.sv
module vexdec_collector
  import vexdec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5,
  parameter logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_i,
  output logic              busy,
  output logic              fin,
  output form_e             fin_form,
  output logic [BYTE_W-1:0] mid_byte
);

  col_state_e        state_q, state_d;
  logic              mid_en;
  logic [BYTE_W-1:0] mid_q;

  always_comb begin
    state_d  = state_q;
    fin      = 1'b0;
    fin_form = FORM_NONE;
    mid_en   = 1'b0;
    if (flush) begin
      state_d = ST_IDLE;
    end else if (take) begin
      case (state_q)
        ST_IDLE: begin
          if (byte_i == LEAD_SHORT)     state_d = ST_SHORT_P1;
          else if (byte_i == LEAD_LONG) state_d = ST_LONG_P1;
          else begin
            fin      = 1'b1;
            fin_form = FORM_NONE;
          end
        end
        ST_SHORT_P1: begin
          fin      = 1'b1;
          fin_form = FORM_SHORT;
          state_d  = ST_IDLE;
        end
        ST_LONG_P1: begin
          mid_en  = 1'b1;
          state_d = ST_LONG_P2;
        end
        ST_LONG_P2: begin
          fin      = 1'b1;
          fin_form = FORM_LONG;
          state_d  = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mid_q <= '0;
    else if (mid_en) mid_q <= byte_i;
  end

  assign busy     = (state_q != ST_IDLE);
  assign mid_byte = mid_q;

  // R11: a flush leaves the collector idle on the next cycle
  assert_flush_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (state_q == ST_IDLE));

  // R3: the middle long-form byte always leads to the third-byte state
  assert_long_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LONG_P1 && take && !flush) |=> (state_q == ST_LONG_P2));

endmodule

// File: rtl/vexdec_unpack.sv
module vexdec_unpack
  import vexdec_pkg::*;
(
  input  form_e             form,
  input  logic [BYTE_W-1:0] mid_byte,
  input  logic [BYTE_W-1:0] last_byte,
  input  logic              scalar_op,
  input  logic              single_src,
  input  logic              shift_class,
  input  logic              w_ignored,
  output rec_t              rec_o
);

  logic             lbit;
  logic [SEL_W-1:0] sel;

  always_comb begin
    rec_o = '0;
    lbit  = last_byte[2];
    sel   = mid_byte[SEL_W-1:0];
    case (form)
      FORM_SHORT: begin
        rec_o.prefixed = 1'b1;
        rec_o.len      = FORM_SHORT;
        rec_o.r        = ~last_byte[7];
        rec_o.map      = MAP_0F;
        rec_o.w        = 1'b0;
      end
      FORM_LONG: begin
        rec_o.prefixed = 1'b1;
        rec_o.len      = FORM_LONG;
        rec_o.r        = ~mid_byte[7];
        rec_o.x        = ~mid_byte[6];
        rec_o.b        = ~mid_byte[5];
        case (sel)
          5'd1:    rec_o.map = MAP_0F;
          5'd2:    rec_o.map = MAP_0F38;
          5'd3:    rec_o.map = MAP_0F3A;
          default: begin
            rec_o.map     = MAP_NONE;
            rec_o.illegal = 1'b1;
          end
        endcase
        rec_o.w = last_byte[7] & ~w_ignored;
      end
      default: rec_o.raw = last_byte;
    endcase
    if (form != FORM_NONE) begin
      rec_o.w_ign     = w_ignored;
      rec_o.vreg      = ~last_byte[6:3];
      rec_o.pp        = last_byte[1:0];
      rec_o.vreg_used = ~(single_src & ~shift_class);
      if (lbit)           rec_o.vlen = VL_256;
      else if (scalar_op) rec_o.vlen = VL_SCALAR;
      else                rec_o.vlen = VL_128;
    end
  end

endmodule

// File: rtl/vexdec_record_reg.sv
module vexdec_record_reg
  import vexdec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  rec_t rec_d,
  output logic valid_q,
  output rec_t rec_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    rec_q <= '0;
    else if (load) rec_q <= rec_d;
  end

  // R6: the short form never reports a widening bit
  assert_short_w_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && rec_q.len == FORM_SHORT) |-> !rec_q.w);

  // R6: a disregarded widening bit never reaches the output
  assert_w_ignored_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && rec_q.w_ign) |-> !rec_q.w);

  // R4: an illegal map select carries no map
  assert_illegal_no_map_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && rec_q.illegal) |-> (rec_q.map == MAP_NONE && rec_q.len == FORM_LONG));

  // R10: a plain byte record carries no prefix length
  assert_plain_no_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !rec_q.prefixed) |-> (rec_q.len == FORM_NONE && !rec_q.vreg_used));

endmodule

// File: rtl/vex_prefix_decoder.sv
module vex_prefix_decoder
  import vexdec_pkg::*;
#(
  parameter logic [BYTE_W-1:0] LEAD_SHORT = 8'hC5,
  parameter logic [BYTE_W-1:0] LEAD_LONG  = 8'hC4,
  parameter int                RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              scalar_op,
  input  logic              single_src,
  input  logic              shift_class,
  input  logic              w_ignored,
  output logic              rec_valid,
  output logic              rec_prefixed,
  output logic [1:0]        rec_len,
  output logic              rec_r,
  output logic              rec_x,
  output logic              rec_b,
  output logic [1:0]        rec_map,
  output logic              rec_illegal,
  output logic              rec_w,
  output logic              rec_w_ignored,
  output logic [VREG_W-1:0] rec_vreg,
  output logic              rec_vreg_used,
  output logic [1:0]        rec_vlen,
  output logic [1:0]        rec_pp,
  output logic [BYTE_W-1:0] rec_byte
);

  // reset: asserted asynchronously, released after RST_STAGES edges
  logic [RST_STAGES-1:0] sync_q;
  logic                  rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = sync_q[RST_STAGES-1];

  logic              take;
  logic              busy;
  logic              fin;
  form_e             fin_form;
  logic [BYTE_W-1:0] mid_byte;
  rec_t              rec_d;
  rec_t              rec_q;

  assign in_ready = rst_sync_n & ~flush;
  assign take     = in_valid & in_ready;

  vexdec_collector #(
    .LEAD_SHORT(LEAD_SHORT),
    .LEAD_LONG (LEAD_LONG)
  ) u_collector (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flush   (flush),
    .take    (take),
    .byte_i  (in_byte),
    .busy    (busy),
    .fin     (fin),
    .fin_form(fin_form),
    .mid_byte(mid_byte)
  );

  vexdec_unpack u_unpack (
    .form       (fin_form),
    .mid_byte   (mid_byte),
    .last_byte  (in_byte),
    .scalar_op  (scalar_op),
    .single_src (single_src),
    .shift_class(shift_class),
    .w_ignored  (w_ignored),
    .rec_o      (rec_d)
  );

  vexdec_record_reg u_record (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (fin),
    .rec_d  (rec_d),
    .valid_q(rec_valid),
    .rec_q  (rec_q)
  );

  assign rec_prefixed  = rec_q.prefixed;
  assign rec_len       = rec_q.len;
  assign rec_r         = rec_q.r;
  assign rec_x         = rec_q.x;
  assign rec_b         = rec_q.b;
  assign rec_map       = rec_q.map;
  assign rec_illegal   = rec_q.illegal;
  assign rec_w         = rec_q.w;
  assign rec_w_ignored = rec_q.w_ign;
  assign rec_vreg      = rec_q.vreg;
  assign rec_vreg_used = rec_q.vreg_used;
  assign rec_vlen      = rec_q.vlen;
  assign rec_pp        = rec_q.pp;
  assign rec_byte      = rec_q.raw;

  // R13: taking a lead byte from idle produces no record next cycle
  assert_lead_no_record_R13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!busy && take && (in_byte == LEAD_SHORT || in_byte == LEAD_LONG)) |=> !rec_valid);

  // R1: nothing is taken while flushing
  assert_flush_blocks_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flush |=> !rec_valid);

endmodule

// File: tb/vex_prefix_decoder_bench.sv
`timescale 1ns/1ps
module vex_prefix_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_byte = 8'h00;
  logic       scalar_op = 1'b0;
  logic       single_src = 1'b0;
  logic       shift_class = 1'b0;
  logic       w_ignored = 1'b0;
  logic       rec_valid, rec_prefixed, rec_r, rec_x, rec_b, rec_illegal;
  logic       rec_w, rec_w_ignored, rec_vreg_used;
  logic [1:0] rec_len, rec_map, rec_vlen, rec_pp;
  logic [3:0] rec_vreg;
  logic [7:0] rec_byte;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vex_prefix_decoder u_vex_prefix_decoder (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_byte(in_byte), .scalar_op(scalar_op),
    .single_src(single_src), .shift_class(shift_class), .w_ignored(w_ignored),
    .rec_valid(rec_valid), .rec_prefixed(rec_prefixed), .rec_len(rec_len),
    .rec_r(rec_r), .rec_x(rec_x), .rec_b(rec_b), .rec_map(rec_map),
    .rec_illegal(rec_illegal), .rec_w(rec_w), .rec_w_ignored(rec_w_ignored),
    .rec_vreg(rec_vreg), .rec_vreg_used(rec_vreg_used), .rec_vlen(rec_vlen),
    .rec_pp(rec_pp), .rec_byte(rec_byte)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [28:0] rec_now();
    return {rec_valid, rec_prefixed, rec_len, rec_r, rec_x, rec_b, rec_map,
            rec_illegal, rec_w, rec_w_ignored, rec_vreg, rec_vreg_used,
            rec_vlen, rec_pp, rec_byte};
  endfunction

  function automatic logic [28:0] mk(input logic pf, input logic [1:0] len,
      input logic r, input logic x, input logic b, input logic [1:0] map,
      input logic ill, input logic w, input logic wi, input logic [3:0] vreg,
      input logic used, input logic [1:0] vlen, input logic [1:0] pp,
      input logic [7:0] raw);
    return {1'b1, pf, len, r, x, b, map, ill, w, wi, vreg, used, vlen, pp, raw};
  endfunction

  task automatic modes(input logic s, input logic ss, input logic sh, input logic wi);
    scalar_op = s; single_src = ss; shift_class = sh; w_ignored = wi;
  endtask

  // called at a negedge; byte is taken at the next posedge
  task automatic put(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 ready in reset", {31'd0, in_ready}, 32'd0);
    chk("R12 valid in reset", {31'd0, rec_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready one edge after release", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R1 ready after sync", {31'd0, in_ready}, 32'd1);
    chk("R12 no record after reset", {31'd0, rec_valid}, 32'd0);
  endtask

  task automatic t_short_form();
    put(8'hC5);
    chk("R13 no record mid short prefix", {31'd0, rec_valid}, 32'd0);
    put(8'h75);
    chk("R2 R5 R7 R9 short form record", {3'd0, rec_now()},
        {3'd0, mk(1, 2, 1, 0, 0, 1, 0, 0, 0, 4'd1, 1, 2'd1, 2'd1, 8'h00)});
    @(negedge clk);
    chk("R13 record lasts one cycle", {31'd0, rec_valid}, 32'd0);
    // lead byte value used as payload; w_ignored echoed, W still 0
    modes(0, 0, 0, 1);
    put(8'hC5);
    put(8'hC4);
    modes(0, 0, 0, 0);
    chk("R2 R6 lead value as payload", {3'd0, rec_now()},
        {3'd0, mk(1, 2, 0, 0, 0, 1, 0, 0, 1, 4'd7, 1, 2'd1, 2'd0, 8'h00)});
  endtask

  task automatic t_long_form();
    modes(1, 0, 0, 0);
    put(8'hC4);
    put(8'hA2);
    chk("R13 no record after byte 2", {31'd0, rec_valid}, 32'd0);
    put(8'h83);
    modes(0, 0, 0, 0);
    chk("R3 R4 R5 R6 R7 long form scalar", {3'd0, rec_now()},
        {3'd0, mk(1, 3, 0, 1, 0, 2, 0, 1, 0, 4'd15, 1, 2'd2, 2'd3, 8'h00)});
  endtask

  task automatic t_long_ignore_w();
    modes(1, 1, 0, 1);
    put(8'hC4);
    put(8'h03);
    put(8'hFE);
    modes(0, 0, 0, 0);
    chk("R3 R6 R7 R8 R9 W ignored, single source", {3'd0, rec_now()},
        {3'd0, mk(1, 3, 1, 1, 1, 3, 0, 0, 1, 4'd0, 0, 2'd1, 2'd2, 8'h00)});
  endtask

  task automatic t_bad_map();
    put(8'hC4); put(8'hE0); put(8'h7C);
    chk("R4 map select 0 illegal", {3'd0, rec_now()},
        {3'd0, mk(1, 3, 0, 0, 0, 0, 1, 0, 0, 4'd0, 1, 2'd1, 2'd0, 8'h00)});
    put(8'hC4); put(8'hFF); put(8'h7C);
    chk("R4 map select 31 illegal", {3'd0, rec_now()},
        {3'd0, mk(1, 3, 0, 0, 0, 0, 1, 0, 0, 4'd0, 1, 2'd1, 2'd0, 8'h00)});
    put(8'hC4); put(8'hE1); put(8'h7C);
    chk("R4 map select 1 legal", {3'd0, rec_now()},
        {3'd0, mk(1, 3, 0, 0, 0, 1, 0, 0, 0, 4'd0, 1, 2'd1, 2'd0, 8'h00)});
  endtask

  task automatic t_single_source();
    modes(0, 1, 1, 0);
    put(8'hC5); put(8'hF8);
    chk("R8 shift keeps register", {3'd0, rec_now()},
        {3'd0, mk(1, 2, 0, 0, 0, 1, 0, 0, 0, 4'd0, 1, 2'd0, 2'd0, 8'h00)});
    modes(1, 1, 0, 0);
    put(8'hC5); put(8'hF8);
    modes(0, 0, 0, 0);
    chk("R7 R8 R14 single source scalar", {3'd0, rec_now()},
        {3'd0, mk(1, 2, 0, 0, 0, 1, 0, 0, 0, 4'd0, 0, 2'd2, 2'd0, 8'h00)});
  endtask

  task automatic t_plain_bytes();
    modes(1, 1, 0, 1);
    put(8'h90);
    modes(0, 0, 0, 0);
    chk("R10 plain byte, qualifiers ignored", {3'd0, rec_now()},
        {3'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 2'd0, 2'd0, 8'h90)});
    in_valid = 1'b1;
    in_byte  = 8'h48;
    @(negedge clk);
    in_byte  = 8'h8B;
    chk("R10 R13 back-to-back first", {3'd0, rec_now()},
        {3'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 2'd0, 2'd0, 8'h48)});
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 R13 back-to-back second", {3'd0, rec_now()},
        {3'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 2'd0, 2'd0, 8'h8B)});
  endtask

  task automatic t_gaps();
    put(8'hC4);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R13 idle after lead", {31'd0, rec_valid}, 32'd0);
    end
    put(8'hA2);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R13 idle after byte 2", {31'd0, rec_valid}, 32'd0);
    end
    put(8'h83);
    chk("R7 R13 long form across gaps", {3'd0, rec_now()},
        {3'd0, mk(1, 3, 0, 1, 0, 2, 0, 1, 0, 4'd15, 1, 2'd0, 2'd3, 8'h00)});
    @(negedge clk);
    chk("R13 pulse ends", {31'd0, rec_valid}, 32'd0);
  endtask

  task automatic t_flush();
    put(8'hC4);
    put(8'hA2);
    flush    = 1'b1;
    in_valid = 1'b1;
    in_byte  = 8'h55;
    #1;
    chk("R1 ready low in flush", {31'd0, in_ready}, 32'd0);
    @(negedge clk);
    flush    = 1'b0;
    in_valid = 1'b0;
    chk("R1 R11 no record from flushed byte", {31'd0, rec_valid}, 32'd0);
    put(8'h83);
    chk("R11 byte after flush is a first byte", {3'd0, rec_now()},
        {3'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 2'd0, 2'd0, 8'h83)});
    put(8'hC5);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    put(8'h75);
    chk("R11 short prefix dropped by flush", {3'd0, rec_now()},
        {3'd0, mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 4'd0, 0, 2'd0, 2'd0, 8'h75)});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R13: actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_short_form();
    t_long_form();
    t_long_ignore_w();
    t_bad_map();
    t_single_source();
    t_plain_bytes();
    t_gaps();
    t_flush();
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule